// File: doc/BRIEF.md
# Paged Evaluation Stack Cache

This block is a small on-chip memory that keeps the top of a language evaluation stack close to the datapath. The storage is split into pages of 512 words of 32 bits, each word stored with a parity bit. Pages come in pairs. The first page of a pair holds the stack. The second is a scratch page, used as extra fast registers without disturbing the stack contents. The page-pair index field is four bits wide, so sixteen pairs can be named. Only the first two pairs are built; naming any other pair is an error.

A single 9-bit word pointer addresses the stack page. Push and pop commands step the pointer up and down. A load command sets it to any value. Random read and write commands address either page of the selected pair directly, through a separate address input, and leave the pointer alone. Every read, whether a pop or a random read, returns its word two cycles after the command is issued. A new command can be accepted every cycle, so reads can be streamed one word per cycle. Parity is generated by the producer of the write data and stored with the word. The block checks it when the word comes out of the read pipeline.

Top module: `stk_cache`

## Requirements
- R1: After reset, `ptr_o` is 0, and `ovf_o`, `udf_o`, `rvalid_o`, `parity_err_o` and `sel_err_o` are all 0.
- R2: A push (`cmd_op_i` = 0) first increments the pointer and then writes `wdata_i` at the new pointer in the stack page. The new pointer value appears on `ptr_o` in the cycle after the command.
- R3: A pop (`cmd_op_i` = 1) reads the stack word at the current pointer and then decrements the pointer.
- R4: A random read (`cmd_op_i` = 2) and a random write (`cmd_op_i` = 3) access the word at `cmd_addr_i` in the page chosen by `scratch_i`. Neither changes the pointer.
- R5: A load (`cmd_op_i` = 4) sets the pointer to `cmd_addr_i` and clears both the overflow and the underflow flag.
- R6: A read command issued in cycle c presents `rvalid_o` and `rdata_o` in cycle c+2. Read commands issued back to back return their words on consecutive cycles, in issue order.
- R7: The pointer wraps modulo 512. A push from 511 to 0 sets `ovf_o`, and a pop from 0 to 511 sets `udf_o`. Each flag stays set until a load or a reset.
- R8: Push and pop always use the stack page (`scratch_i` ignored). A write to the scratch page (`scratch_i` = 1) leaves the stack word at the same address unchanged.
- R9: Page pairs 0 and 1 are separate storage: a write to one pair does not change the word at the same address in the other pair.
- R10: When `pair_sel_i` is 2 or more, the command is discarded: no memory write and no pointer change. `sel_err_o` pulses in cycle c+2. If the command was a read or a pop, `rvalid_o` is also asserted in cycle c+2 with `rdata_o` = 0.
- R11: Each stored word holds `wdata_i` and `wpar_i`. When a read returns a word whose 33 stored bits contain an even number of ones, `parity_err_o` is asserted together with `rvalid_o`. Odd parity is the correct state.
- R12: Operation codes 5, 6 and 7 have no effect on the pointer, on the flags or on the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | A command is presented this cycle |
| cmd_op_i | input | 3 | 0 push, 1 pop, 2 read, 3 write, 4 load pointer |
| cmd_addr_i | input | 9 | Word address for read, write and load |
| pair_sel_i | input | 4 | Page-pair index |
| scratch_i | input | 1 | Selects the scratch page for random read and write |
| wdata_i | input | 32 | Write data for push and write |
| wpar_i | input | 1 | Odd parity bit that goes with `wdata_i` |
| rdata_o | output | 32 | Read data |
| rvalid_o | output | 1 | `rdata_o` holds a read result |
| parity_err_o | output | 1 | The returned word failed its parity check |
| sel_err_o | output | 1 | The command two cycles earlier named an unimplemented pair |
| ptr_o | output | 9 | Current stack pointer |
| ovf_o | output | 1 | Sticky flag: the pointer wrapped on a push |
| udf_o | output | 1 | Sticky flag: the pointer wrapped on a pop |

## Verification
The hardest case to reach is a parity failure. The storage offers no way to corrupt a stored bit from outside, so the bench writes a word along with a deliberately wrong parity bit on `wpar_i`. It then reads that word back and expects the error flag on the same cycle as the valid data. The wrap flags need the pointer to sit at an edge of the page. A load places it at 511 first, so one push and one pop are enough to cross the boundary in both directions, instead of 512 pushes.

// File: rtl/stk_cache_pkg.sv
package stk_cache_pkg;

  typedef enum logic [2:0] {
    OP_PUSH = 3'd0,
    OP_POP  = 3'd1,
    OP_RD   = 3'd2,
    OP_WR   = 3'd3,
    OP_LOAD = 3'd4
  } stk_op_e;

  // odd parity over data and its check bit
  function automatic logic par_ok(input logic [32:0] word);
    return ^word;
  endfunction

endpackage

// File: rtl/stk_ptr_ctrl.sv
module stk_ptr_ctrl #(
  parameter int PTR_W = 9
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic             pop_i,
  input  logic             load_i,
  input  logic [PTR_W-1:0] load_val_i,
  output logic [PTR_W-1:0] ptr_o,
  output logic [PTR_W-1:0] ptr_inc_o,
  output logic             ovf_o,
  output logic             udf_o
);

  localparam logic [PTR_W-1:0] PTR_MAX = '1;

  logic [PTR_W-1:0] ptr_q, ptr_d;
  logic             ovf_q, udf_q;

  assign ptr_inc_o = ptr_q + PTR_W'(1);

  always_comb begin
    ptr_d = ptr_q;
    if (load_i)      ptr_d = load_val_i;
    else if (push_i) ptr_d = ptr_inc_o;
    else if (pop_i)  ptr_d = ptr_q - PTR_W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q <= '0;
      ovf_q <= 1'b0;
      udf_q <= 1'b0;
    end else begin
      ptr_q <= ptr_d;
      if (load_i) begin
        ovf_q <= 1'b0;
        udf_q <= 1'b0;
      end else begin
        if (push_i && ptr_q == PTR_MAX) ovf_q <= 1'b1;
        if (pop_i && ptr_q == '0)       udf_q <= 1'b1;
      end
    end
  end

  assign ptr_o = ptr_q;
  assign ovf_o = ovf_q;
  assign udf_o = udf_q;

  // R2
  push_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i && !load_i |=> ptr_q == PTR_W'($past(ptr_q) + PTR_W'(1)));
  // R3
  pop_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i && !load_i |=> ptr_q == PTR_W'($past(ptr_q) - PTR_W'(1)));
  // R7
  ovf_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_q && !load_i |=> ovf_q);
  // R7
  udf_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    udf_q && !load_i |=> udf_q);
  // R5
  load_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> !ovf_q && !udf_q && ptr_q == $past(load_val_i));

endmodule

// File: rtl/stk_page_ram.sv
module stk_page_ram #(
  parameter int DEPTH = 512,
  parameter int W     = 33
) (
  input  logic                     clk_i,
  input  logic                     we_i,
  input  logic [$clog2(DEPTH)-1:0] waddr_i,
  input  logic [W-1:0]             wdata_i,
  input  logic                     re_i,
  input  logic [$clog2(DEPTH)-1:0] raddr_i,
  output logic [W-1:0]             rdata_o
);

  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem[waddr_i] <= wdata_i;
    if (re_i) rdata_o <= mem[raddr_i];
  end

endmodule

// File: rtl/stk_rd_pipe.sv
module stk_rd_pipe #(
  parameter int DATA_W = 32,
  parameter int PG_W   = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_req_i,
  input  logic              sel_err_req_i,
  input  logic [PG_W-1:0]   page_i,
  output logic [PG_W-1:0]   page_q_o,
  input  logic [DATA_W:0]   word_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rvalid_o,
  output logic              par_err_o,
  output logic              sel_err_o
);

  import stk_cache_pkg::*;

  logic            s1_rd, s1_sel;
  logic [PG_W-1:0] s1_page;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_rd     <= 1'b0;
      s1_sel    <= 1'b0;
      s1_page   <= '0;
      rvalid_o  <= 1'b0;
      rdata_o   <= '0;
      par_err_o <= 1'b0;
      sel_err_o <= 1'b0;
    end else begin
      s1_rd     <= rd_req_i;
      s1_sel    <= sel_err_req_i;
      s1_page   <= page_i;
      rvalid_o  <= s1_rd;
      sel_err_o <= s1_sel;
      par_err_o <= s1_rd && !s1_sel && !par_ok(word_i);
      if (s1_rd) rdata_o <= s1_sel ? '0 : word_i[DATA_W-1:0];
    end
  end

  assign page_q_o = s1_page;

  // R6
  latency_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_i |-> ##2 rvalid_o);
  // R11
  par_err_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    par_err_o |-> rvalid_o);
  // R10
  sel_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_err_o && rvalid_o |-> rdata_o == '0 && !par_err_o);

endmodule

// File: rtl/stk_cache.sv
module stk_cache #(
  parameter int DATA_W     = 32,
  parameter int DEPTH      = 512,
  parameter int PAIR_W     = 4,
  parameter int PAIRS_IMPL = 2
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     cmd_valid_i,
  input  logic [2:0]               cmd_op_i,
  input  logic [$clog2(DEPTH)-1:0] cmd_addr_i,
  input  logic [PAIR_W-1:0]        pair_sel_i,
  input  logic                     scratch_i,
  input  logic [DATA_W-1:0]        wdata_i,
  input  logic                     wpar_i,
  output logic [DATA_W-1:0]        rdata_o,
  output logic                     rvalid_o,
  output logic                     parity_err_o,
  output logic                     sel_err_o,
  output logic [$clog2(DEPTH)-1:0] ptr_o,
  output logic                     ovf_o,
  output logic                     udf_o
);

  import stk_cache_pkg::*;

  localparam int PTR_W = $clog2(DEPTH);
  localparam int PAGES = 2 * PAIRS_IMPL;
  localparam int PG_W  = $clog2(PAGES);
  localparam int WW    = DATA_W + 1;

  stk_op_e op;
  logic    sel_ok, act, is_push, is_pop, is_rd, is_wr, is_load;
  logic    mem_scr, wr_en, rd_en;
  logic [PG_W-1:0]  pg, pg_q;
  logic [PTR_W-1:0] ptr_inc, acc_addr;
  logic [WW-1:0]    ram_q [PAGES];

  assign op      = stk_op_e'(cmd_op_i);
  assign sel_ok  = pair_sel_i < PAIR_W'(PAIRS_IMPL);
  assign act     = cmd_valid_i && sel_ok;
  assign is_push = act && op == OP_PUSH;
  assign is_pop  = act && op == OP_POP;
  assign is_rd   = act && op == OP_RD;
  assign is_wr   = act && op == OP_WR;
  assign is_load = act && op == OP_LOAD;

  // stack traffic always lands in the stack member of the pair
  assign mem_scr  = (op == OP_RD || op == OP_WR) && scratch_i;
  assign pg       = PG_W'({pair_sel_i, mem_scr});
  assign acc_addr = is_push ? ptr_inc : (is_pop ? ptr_o : cmd_addr_i);
  assign wr_en    = is_push || is_wr;
  assign rd_en    = is_pop || is_rd;

  stk_ptr_ctrl #(.PTR_W(PTR_W)) i_ptr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .push_i     (is_push),
    .pop_i      (is_pop),
    .load_i     (is_load),
    .load_val_i (cmd_addr_i),
    .ptr_o      (ptr_o),
    .ptr_inc_o  (ptr_inc),
    .ovf_o      (ovf_o),
    .udf_o      (udf_o)
  );

  for (genvar g = 0; g < PAGES; g++) begin : g_page
    stk_page_ram #(.DEPTH(DEPTH), .W(WW)) i_ram (
      .clk_i   (clk_i),
      .we_i    (wr_en && pg == PG_W'(g)),
      .waddr_i (acc_addr),
      .wdata_i ({wpar_i, wdata_i}),
      .re_i    (rd_en && pg == PG_W'(g)),
      .raddr_i (acc_addr),
      .rdata_o (ram_q[g])
    );
  end

  stk_rd_pipe #(.DATA_W(DATA_W), .PG_W(PG_W)) i_pipe (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .rd_req_i      (cmd_valid_i && (op == OP_POP || op == OP_RD)),
    .sel_err_req_i (cmd_valid_i && !sel_ok),
    .page_i        (pg),
    .page_q_o      (pg_q),
    .word_i        (ram_q[pg_q]),
    .rdata_o       (rdata_o),
    .rvalid_o      (rvalid_o),
    .par_err_o     (parity_err_o),
    .sel_err_o     (sel_err_o)
  );

  // R10
  bad_sel_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_i && !sel_ok |=> $stable(ptr_o) && $stable(ovf_o) && $stable(udf_o));
  // R4
  rand_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_rd || is_wr |=> $stable(ptr_o));
  // R12
  bad_op_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_i && cmd_op_i > 3'd4 |=> $stable(ptr_o) && $stable(ovf_o) && $stable(udf_o));

endmodule

// File: tb/test_stk_cache.sv
module test_stk_cache;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [2:0]  cmd_op = '0;
  logic [8:0]  cmd_addr = '0;
  logic [3:0]  pair_sel = '0;
  logic        scratch = 1'b0;
  logic [31:0] wdata = '0;
  logic        wpar = 1'b0;
  logic [31:0] rdata;
  logic        rvalid, par_err, sel_err, ovf, udf;
  logic [8:0]  ptr;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  stk_cache i_stk_cache (
    .clk_i(clk), .rst_ni(rst_n), .cmd_valid_i(cmd_valid), .cmd_op_i(cmd_op),
    .cmd_addr_i(cmd_addr), .pair_sel_i(pair_sel), .scratch_i(scratch),
    .wdata_i(wdata), .wpar_i(wpar), .rdata_o(rdata), .rvalid_o(rvalid),
    .parity_err_o(par_err), .sel_err_o(sel_err), .ptr_o(ptr), .ovf_o(ovf), .udf_o(udf)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // drive at a falling edge, return one falling edge later
  task automatic cmd(input logic [2:0] op, input logic [8:0] a, input logic [3:0] pr,
                     input logic sc, input logic [31:0] d, input logic bad_par);
    cmd_valid = 1'b1; cmd_op = op; cmd_addr = a; pair_sel = pr; scratch = sc;
    wdata = d; wpar = bad_par ? ^d : ~^d;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic xfer(input logic [2:0] op, input logic [8:0] a, input logic [3:0] pr,
                      input logic sc, output logic [31:0] d, output logic v,
                      output logic pe, output logic se);
    cmd(op, a, pr, sc, 32'h0, 1'b0);
    @(negedge clk);
    d = rdata; v = rvalid; pe = par_err; se = sel_err;
  endtask

  task automatic t_reset();
    chk(ptr == 0 && !ovf && !udf, "R1 ptr/flags", {ptr, ovf, udf}, 0);
    chk(!rvalid && !par_err && !sel_err, "R1 outputs", {rvalid, par_err, sel_err}, 0);
  endtask

  task automatic t_push_pop();
    logic [31:0] d; logic v, pe, se;
    cmd(3'd0, 9'd0, 4'd0, 1'b1, 32'hA1A1_0001, 1'b0);
    chk(ptr == 9'd1, "R2 ptr after push", ptr, 1);
    cmd(3'd0, 9'd0, 4'd0, 1'b0, 32'hB2B2_0002, 1'b0);
    chk(ptr == 9'd2, "R2 ptr after push", ptr, 2);
    xfer(3'd2, 9'd1, 4'd0, 1'b0, d, v, pe, se);
    chk(v && d == 32'hA1A1_0001, "R2 word at incremented ptr", d, 32'hA1A1_0001);
    xfer(3'd1, 9'd0, 4'd0, 1'b1, d, v, pe, se);
    chk(v && d == 32'hB2B2_0002, "R3 pop data", d, 32'hB2B2_0002);
    chk(ptr == 9'd1, "R3 ptr after pop", ptr, 1);
    xfer(3'd1, 9'd0, 4'd0, 1'b0, d, v, pe, se);
    chk(v && d == 32'hA1A1_0001 && ptr == 0, "R3 second pop", d, 32'hA1A1_0001);
  endtask

  task automatic t_random();
    logic [31:0] d; logic v, pe, se;
    cmd(3'd3, 9'd100, 4'd0, 1'b0, 32'h1234_5678, 1'b0);
    chk(ptr == 0, "R4 write keeps ptr", ptr, 0);
    xfer(3'd2, 9'd100, 4'd0, 1'b0, d, v, pe, se);
    chk(v && d == 32'h1234_5678 && !pe, "R4 random read", d, 32'h1234_5678);
    chk(ptr == 0, "R4 read keeps ptr", ptr, 0);
  endtask

  task automatic t_stream();
    logic [31:0] exp [4];
    for (int i = 0; i < 4; i++) begin
      exp[i] = 32'hC0DE_0000 + 32'(i * 7 + 3);
      cmd(3'd3, 9'(200 + i), 4'd1, 1'b0, exp[i], 1'b0);
    end
    chk(!rvalid, "R6 idle before stream", rvalid, 0);
    for (int i = 0; i < 6; i++) begin
      if (i >= 2) chk(rvalid && rdata == exp[i-2], "R6 streamed word", rdata, exp[i-2]);
      if (i == 1) chk(!rvalid, "R6 no data at c+1", rvalid, 0);
      if (i < 4) begin
        cmd_valid = 1'b1; cmd_op = 3'd2; cmd_addr = 9'(200 + i); pair_sel = 4'd1; scratch = 1'b0;
      end else cmd_valid = 1'b0;
      @(negedge clk);
    end
    chk(!rvalid, "R6 valid drops after stream", rvalid, 0);
  endtask

  task automatic t_wrap();
    logic [31:0] d; logic v, pe, se;
    cmd(3'd4, 9'd511, 4'd0, 1'b0, 32'h0, 1'b0);
    chk(ptr == 9'd511 && !ovf && !udf, "R5 load", ptr, 511);
    cmd(3'd0, 9'd0, 4'd0, 1'b0, 32'hDEAD_0000, 1'b0);
    chk(ptr == 0 && ovf && !udf, "R7 push wrap sets ovf", {ptr, ovf, udf}, 2);
    xfer(3'd1, 9'd0, 4'd0, 1'b0, d, v, pe, se);
    chk(v && d == 32'hDEAD_0000, "R7 pop at 0 data", d, 32'hDEAD_0000);
    chk(ptr == 9'd511 && ovf && udf, "R7 pop wrap sets udf, ovf sticky", {ptr, ovf, udf}, {9'd511, 2'b11});
    cmd(3'd3, 9'd3, 4'd0, 1'b0, 32'h0, 1'b0);
    chk(ovf && udf, "R7 flags stay set", {ovf, udf}, 3);
    cmd(3'd4, 9'd5, 4'd0, 1'b0, 32'h0, 1'b0);
    chk(ptr == 9'd5 && !ovf && !udf, "R5 load clears flags", {ptr, ovf, udf}, {9'd5, 2'b00});
  endtask

  task automatic t_member();
    logic [31:0] d; logic v, pe, se;
    cmd(3'd0, 9'd0, 4'd0, 1'b1, 32'h5AC0_0006, 1'b0);
    chk(ptr == 9'd6, "R8 push ptr", ptr, 6);
    cmd(3'd3, 9'd6, 4'd0, 1'b1, 32'h5C5C_0006, 1'b0);
    xfer(3'd2, 9'd6, 4'd0, 1'b0, d, v, pe, se);
    chk(d == 32'h5AC0_0006, "R8 stack word kept, push ignores scratch_i", d, 32'h5AC0_0006);
    xfer(3'd2, 9'd6, 4'd0, 1'b1, d, v, pe, se);
    chk(d == 32'h5C5C_0006, "R8 scratch word", d, 32'h5C5C_0006);
  endtask

  task automatic t_pairs();
    logic [31:0] d; logic v, pe, se;
    cmd(3'd3, 9'd7, 4'd0, 1'b0, 32'h0000_7770, 1'b0);
    cmd(3'd3, 9'd7, 4'd1, 1'b0, 32'h0000_7771, 1'b0);
    xfer(3'd2, 9'd7, 4'd0, 1'b0, d, v, pe, se);
    chk(d == 32'h0000_7770, "R9 pair 0 word", d, 32'h0000_7770);
    xfer(3'd2, 9'd7, 4'd1, 1'b0, d, v, pe, se);
    chk(d == 32'h0000_7771, "R9 pair 1 word", d, 32'h0000_7771);
  endtask

  task automatic t_badsel();
    logic [31:0] d; logic v, pe, se;
    cmd(3'd0, 9'd0, 4'd3, 1'b0, 32'hBAD0_BAD0, 1'b0);
    chk(ptr == 9'd6, "R10 push discarded", ptr, 6);
    chk(!sel_err, "R10 no flag at c+1", sel_err, 0);
    @(negedge clk);
    chk(sel_err && !rvalid, "R10 flag at c+2 for write", {sel_err, rvalid}, 2);
    cmd(3'd3, 9'd6, 4'd2, 1'b0, 32'hBAD1_BAD1, 1'b0);
    xfer(3'd2, 9'd6, 4'd9, 1'b0, d, v, pe, se);
    chk(v && se && d == 0 && !pe, "R10 read of bad pair", {v, se, d}, {2'b11, 32'h0});
    xfer(3'd2, 9'd7, 4'd0, 1'b0, d, v, pe, se);
    chk(!se && d == 32'h0000_7770, "R10 error not sticky", {se, d}, 32'h0000_7770);
    xfer(3'd2, 9'd6, 4'd0, 1'b0, d, v, pe, se);
    chk(d == 32'h5AC0_0006, "R10 stack word untouched", d, 32'h5AC0_0006);
  endtask

  task automatic t_parity();
    logic [31:0] d; logic v, pe, se;
    cmd(3'd3, 9'd40, 4'd1, 1'b1, 32'h0F0F_1357, 1'b1);
    xfer(3'd2, 9'd40, 4'd1, 1'b1, d, v, pe, se);
    chk(v && pe, "R11 bad parity flagged", {v, pe}, 3);
    chk(d == 32'h0F0F_1357, "R11 data still returned", d, 32'h0F0F_1357);
    @(negedge clk);
    chk(!par_err, "R11 flag is per word", par_err, 0);
    cmd(3'd3, 9'd41, 4'd1, 1'b1, 32'h0F0F_1357, 1'b0);
    xfer(3'd2, 9'd41, 4'd1, 1'b1, d, v, pe, se);
    chk(v && !pe, "R11 good parity clean", {v, pe}, 2);
  endtask

  task automatic t_badop();
    for (int o = 5; o < 8; o++) begin
      cmd(3'(o), 9'd300, 4'd0, 1'b0, 32'hFFFF_FFFF, 1'b0);
      @(negedge clk);
      chk(ptr == 9'd6 && !ovf && !udf && !rvalid && !sel_err && !par_err,
          "R12 unused op ignored", {ptr, ovf, udf, rvalid}, {9'd6, 3'b000});
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_push_pop();
    t_random();
    t_stream();
    t_wrap();
    t_member();
    t_pairs();
    t_badsel();
    t_parity();
    t_badop();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule